// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block sits between the register-file read port and the ALU operand register of a short in-order pipeline. For the instruction currently in decode it compares both source register addresses against the destinations of the three instructions ahead of it. These are the instruction in execute, the one in write-back, and the one held for a cycle after write-back. When a source matches, it picks the freshest result instead of the register-file data. The chosen operands are registered, so they are presented to the ALU when the consumer enters execute. With this arrangement, back-to-back dependent ALU instructions need no stall.

The register file in this pipeline makes a write visible to readers only one cycle after write-back. To cover that gap, the unit copies the write-back result into its own hold register and treats it as a third, oldest forwarding source. Results tagged as coming from the multiplier are never forwarded. A matching multiplier destination also masks any older match for that operand, so the stall logic outside the block can act. A write-enable that is low (branches, bubbles) never causes a forward, and neither does a destination of register 0.

Top module: `fwd_unit`

## Requirements
- R1: While rst_ni is low, op_a_o and op_b_o are zero, both select outputs read 0 and fwd_req_o is low.
- R2: If a decode source equals ex_rd_i, and ex_we_i is high, ex_rd_i is nonzero and ex_mul_i is low, then one clock later that operand carries the ex_result_i of the decode cycle and its select reads 1.
- R3: If the nearest match is the write-back stage, then one clock later the operand carries wb_result_i and its select reads 2.
- R4: An ALU result that was in write-back one cycle earlier stays available through the hold register for one more cycle. A source that matches only that instruction gets its result, and its select reads 3.
- R5: When several stages match the same source, the youngest match decides (execute over write-back over hold).
- R6: A producer with its write-enable low, or with destination 0, never causes a forward. A source of register 0 always takes register-file data.
- R7: If the youngest matching producer is a multiplier result, the operand takes register-file data with select 0, even when an older ALU producer also matches.
- R8: With no forward, each operand equals the register-file read data of its source in the decode cycle, and its select reads 0.
- R9: The two operands are selected independently. fwd_req_o is high exactly when at least one of the two selects is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_rs1_i | input | 3 | First source register of the decode instruction |
| dec_rs2_i | input | 3 | Second source register of the decode instruction |
| rf_rd1_i | input | 16 | Register-file read data for dec_rs1_i |
| rf_rd2_i | input | 16 | Register-file read data for dec_rs2_i |
| ex_we_i | input | 1 | Execute-stage instruction writes a register |
| ex_mul_i | input | 1 | Execute-stage result comes from the multiplier |
| ex_rd_i | input | 3 | Execute-stage destination register |
| ex_result_i | input | 16 | Execute-stage result bus |
| wb_we_i | input | 1 | Write-back-stage instruction writes a register |
| wb_mul_i | input | 1 | Write-back-stage result comes from the multiplier |
| wb_rd_i | input | 3 | Write-back-stage destination register |
| wb_result_i | input | 16 | Write-back-stage result bus |
| op_a_o | output | 16 | Registered first ALU operand |
| op_b_o | output | 16 | Registered second ALU operand |
| fwd_a_sel_o | output | 2 | Source of op_a_o: 0 register file, 1 execute, 2 write-back, 3 hold |
| fwd_b_sel_o | output | 2 | Source of op_b_o, same coding |
| fwd_req_o | output | 1 | At least one operand was forwarded |

## Verification
Every output is due exactly one rising edge after the decode-cycle inputs that produced it. The hold source reflects the write-back inputs of the cycle before those. The driver applies each instruction on a falling edge and queues the expected operands and selects at the same time. The monitor pops and compares 5 ns after the following rising edge, so each result is read in the one cycle it belongs to. Expected operand data comes from a precise architectural register model, or from a one-cycle-lagging register-file copy when a multiplier blocks the forward, and never from the design's internals.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF   = 2'd0,
    SRC_EX   = 2'd1,
    SRC_WB   = 2'd2,
    SRC_HOLD = 2'd3
  } src_e;

  // producer slots, youngest first: execute, write-back, hold
  localparam int unsigned NUM_PROD = 3;
  localparam int unsigned NUM_SRC  = 2;
endpackage

// File: rtl/fwd_hazard_cmp.sv
module fwd_hazard_cmp #(
  parameter int unsigned AW = 3
) (
  input  logic          prod_we_i,
  input  logic [AW-1:0] prod_rd_i,
  input  logic [AW-1:0] src_i,
  output logic          hit_o
);
  logic [AW-1:0] diff;

  assign diff  = prod_rd_i ^ src_i;
  assign hit_o = prod_we_i & ~(|diff) & (|prod_rd_i);
endmodule

// File: rtl/fwd_hold_reg.sv
module fwd_hold_reg #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          mul_i,
  input  logic [AW-1:0] rd_i,
  input  logic [W-1:0]  data_i,
  output logic          we_o,
  output logic          mul_o,
  output logic [AW-1:0] rd_o,
  output logic [W-1:0]  data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      mul_o  <= 1'b0;
      rd_o   <= '0;
      data_o <= '0;
    end else begin
      we_o   <= we_i;
      mul_o  <= mul_i;
      rd_o   <= rd_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned NP = NUM_PROD
) (
  input  logic [NP-1:0] hit_i,
  input  logic [NP-1:0] mul_i,
  input  logic [W-1:0]  data_i [NP],
  input  logic [W-1:0]  rf_i,
  output src_e          sel_o,
  output logic [W-1:0]  data_o,
  output logic          req_o
);
  logic done;

  // youngest hit decides; a multiplier hit masks older ones
  always_comb begin
    sel_o  = SRC_RF;
    data_o = rf_i;
    done   = 1'b0;
    for (int i = 0; i < int'(NP); i++) begin
      if (!done && hit_i[i]) begin
        done = 1'b1;
        if (!mul_i[i]) begin
          sel_o  = src_e'(2'(i + 1));
          data_o = data_i[i];
        end
      end
    end
  end

  assign req_o = (sel_o != SRC_RF);
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] dec_rs1_i,
  input  logic [AW-1:0] dec_rs2_i,
  input  logic [W-1:0]  rf_rd1_i,
  input  logic [W-1:0]  rf_rd2_i,
  input  logic          ex_we_i,
  input  logic          ex_mul_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic [W-1:0]  ex_result_i,
  input  logic          wb_we_i,
  input  logic          wb_mul_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic [W-1:0]  wb_result_i,
  output logic [W-1:0]  op_a_o,
  output logic [W-1:0]  op_b_o,
  output logic [1:0]    fwd_a_sel_o,
  output logic [1:0]    fwd_b_sel_o,
  output logic          fwd_req_o
);
  localparam int unsigned NP = NUM_PROD;
  localparam int unsigned NS = NUM_SRC;

  logic          hold_we, hold_mul;
  logic [AW-1:0] hold_rd;
  logic [W-1:0]  hold_data;

  logic [NP-1:0] prod_we, prod_mul;
  logic [AW-1:0] prod_rd   [NP];
  logic [W-1:0]  prod_data [NP];

  logic [AW-1:0] src_addr [NS];
  logic [W-1:0]  src_rf   [NS];
  logic [NP-1:0] hit      [NS];
  src_e          sel      [NS];
  logic [W-1:0]  opnd     [NS];
  logic [NS-1:0] req;

  fwd_hold_reg #(.W(W), .AW(AW)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wb_we_i),
    .mul_i  (wb_mul_i),
    .rd_i   (wb_rd_i),
    .data_i (wb_result_i),
    .we_o   (hold_we),
    .mul_o  (hold_mul),
    .rd_o   (hold_rd),
    .data_o (hold_data)
  );

  assign prod_we   = {hold_we,  wb_we_i,  ex_we_i};
  assign prod_mul  = {hold_mul, wb_mul_i, ex_mul_i};
  assign prod_rd   = '{ex_rd_i, wb_rd_i, hold_rd};
  assign prod_data = '{ex_result_i, wb_result_i, hold_data};

  assign src_addr = '{dec_rs1_i, dec_rs2_i};
  assign src_rf   = '{rf_rd1_i, rf_rd2_i};

  for (genvar s = 0; s < NS; s++) begin : g_src
    for (genvar p = 0; p < NP; p++) begin : g_prod
      fwd_hazard_cmp #(.AW(AW)) u_cmp (
        .prod_we_i (prod_we[p]),
        .prod_rd_i (prod_rd[p]),
        .src_i     (src_addr[s]),
        .hit_o     (hit[s][p])
      );
    end

    fwd_operand_sel #(.W(W), .NP(NP)) u_sel (
      .hit_i  (hit[s]),
      .mul_i  (prod_mul),
      .data_i (prod_data),
      .rf_i   (src_rf[s]),
      .sel_o  (sel[s]),
      .data_o (opnd[s]),
      .req_o  (req[s])
    );
  end

  // execute-stage operand buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a_o      <= '0;
      op_b_o      <= '0;
      fwd_a_sel_o <= SRC_RF;
      fwd_b_sel_o <= SRC_RF;
      fwd_req_o   <= 1'b0;
    end else begin
      op_a_o      <= opnd[0];
      op_b_o      <= opnd[1];
      fwd_a_sel_o <= sel[0];
      fwd_b_sel_o <= sel[1];
      fwd_req_o   <= |req;
    end
  end
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] dec_rs1_i,
  input logic [AW-1:0] dec_rs2_i,
  input logic [W-1:0]  rf_rd1_i,
  input logic          ex_we_i,
  input logic          ex_mul_i,
  input logic [AW-1:0] ex_rd_i,
  input logic [W-1:0]  ex_result_i,
  input logic [W-1:0]  op_a_o,
  input logic [W-1:0]  op_b_o,
  input logic [1:0]    fwd_a_sel_o,
  input logic [1:0]    fwd_b_sel_o,
  input logic          fwd_req_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (op_a_o == '0 && op_b_o == '0 && fwd_a_sel_o == 2'd0
                               && fwd_b_sel_o == 2'd0 && !fwd_req_o);
    end
  end

  a_r2_ex_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_we_i && !ex_mul_i && ex_rd_i != '0 && ex_rd_i == dec_rs1_i)
    |=> (fwd_a_sel_o == 2'd1 && op_a_o == $past(ex_result_i)));

  a_r6_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_rs2_i == '0) |=> (fwd_b_sel_o == 2'd0));

  a_r7_mul_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_we_i && ex_mul_i && ex_rd_i != '0 && ex_rd_i == dec_rs1_i)
    |=> (fwd_a_sel_o == 2'd0));

  a_r8_rf_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_sel_o == 2'd0) |-> (op_a_o == $past(rf_rd1_i)));

  a_r9_req_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_req_o == ((fwd_a_sel_o != 2'd0) || (fwd_b_sel_o != 2'd0)));
endmodule

bind fwd_unit fwd_unit_chk #(.W(W), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dec_rs1_i   (dec_rs1_i),
  .dec_rs2_i   (dec_rs2_i),
  .rf_rd1_i    (rf_rd1_i),
  .ex_we_i     (ex_we_i),
  .ex_mul_i    (ex_mul_i),
  .ex_rd_i     (ex_rd_i),
  .ex_result_i (ex_result_i),
  .op_a_o      (op_a_o),
  .op_b_o      (op_b_o),
  .fwd_a_sel_o (fwd_a_sel_o),
  .fwd_b_sel_o (fwd_b_sel_o),
  .fwd_req_o   (fwd_req_o)
);

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  dec_rs1, dec_rs2, ex_rd, wb_rd;
  logic [15:0] rf_rd1, rf_rd2, ex_res, wb_res;
  logic        ex_we, ex_mul, wb_we, wb_mul;
  logic [15:0] op_a, op_b;
  logic [1:0]  sel_a, sel_b;
  logic        req;

  always #10 clk = ~clk;

  fwd_unit u_fwd_unit (
    .clk_i (clk), .rst_ni (rst_n),
    .dec_rs1_i (dec_rs1), .dec_rs2_i (dec_rs2),
    .rf_rd1_i (rf_rd1), .rf_rd2_i (rf_rd2),
    .ex_we_i (ex_we), .ex_mul_i (ex_mul), .ex_rd_i (ex_rd), .ex_result_i (ex_res),
    .wb_we_i (wb_we), .wb_mul_i (wb_mul), .wb_rd_i (wb_rd), .wb_result_i (wb_res),
    .op_a_o (op_a), .op_b_o (op_b),
    .fwd_a_sel_o (sel_a), .fwd_b_sel_o (sel_b), .fwd_req_o (req)
  );

  typedef struct {
    logic [15:0] a, b;
    logic [1:0]  sa, sb;
    logic        rq;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_checks = 0;
  int          n_errors = 0;
  int          ncyc = 0;
  bit          finished = 0;

  logic [15:0] arch   [8];
  logic [15:0] rf_lag [8];
  logic        h_we [3], h_mul [3];
  logic [2:0]  h_rd [3];
  logic [15:0] h_res [3];

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_src(input logic [2:0] rs, output logic [1:0] s, output logic [15:0] v);
    bit found = 0;
    s = 2'd0;
    v = arch[rs];
    for (int i = 0; i < 3; i++) begin
      if (!found && h_we[i] && h_rd[i] != 3'd0 && h_rd[i] == rs) begin
        found = 1;
        if (h_mul[i]) v = rf_lag[rs];
        else s = 2'(i + 1);
      end
    end
  endfunction

  task automatic issue(input logic we, input logic mul, input logic [2:0] rd,
                       input logic [2:0] rs1, input logic [2:0] rs2, input string tag);
    exp_t        e;
    logic [15:0] res;
    @(negedge clk);
    ref_src(rs1, e.sa, e.a);
    ref_src(rs2, e.sb, e.b);
    e.rq  = (e.sa != 2'd0) || (e.sb != 2'd0);
    e.tag = tag;
    dec_rs1 = rs1; dec_rs2 = rs2;
    rf_rd1  = rf_lag[rs1]; rf_rd2 = rf_lag[rs2];
    ex_we = h_we[0]; ex_mul = h_mul[0]; ex_rd = h_rd[0]; ex_res = h_res[0];
    wb_we = h_we[1]; wb_mul = h_mul[1]; wb_rd = h_rd[1]; wb_res = h_res[1];
    q.push_back(e);
    res = mul ? 16'(arch[rs1] * arch[rs2]) + 16'd1 : arch[rs1] + arch[rs2] + 16'(ncyc * 37);
    if (h_we[2] && h_rd[2] != 3'd0) rf_lag[h_rd[2]] = h_res[2];
    for (int i = 2; i > 0; i--) begin
      h_we[i] = h_we[i-1]; h_mul[i] = h_mul[i-1]; h_rd[i] = h_rd[i-1]; h_res[i] = h_res[i-1];
    end
    h_we[0] = we; h_mul[0] = mul; h_rd[0] = rd; h_res[0] = res;
    if (we && rd != 3'd0) arch[rd] = res;
    ncyc++;
  endtask

  task automatic bubble(input string tag);
    issue(1'b0, 1'b0, 3'd7, 3'd0, 3'd0, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "op_a", op_a, e.a);
        check(e.tag, "op_b", op_b, e.b);
        check(e.tag, "sel_a", 16'(sel_a), 16'(e.sa));
        check(e.tag, "sel_b", 16'(sel_b), 16'(e.sb));
        check({e.tag, "/R9"}, "req", 16'(req), 16'(e.rq));
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      arch[i] = 16'(i * 16'h1111);
      rf_lag[i] = arch[i];
    end
    for (int i = 0; i < 3; i++) begin
      h_we[i] = 0; h_mul[i] = 0; h_rd[i] = 0; h_res[i] = 0;
    end
    rst_n = 1'b0;
    dec_rs1 = 0; dec_rs2 = 0; rf_rd1 = 0; rf_rd2 = 0;
    ex_we = 0; ex_mul = 0; ex_rd = 0; ex_res = 0;
    wb_we = 0; wb_mul = 0; wb_rd = 0; wb_res = 0;
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    check("R1", "op_a", op_a, 16'd0);
    check("R1", "op_b", op_b, 16'd0);
    check("R1", "sel_a", 16'(sel_a), 16'd0);
    check("R1", "sel_b", 16'(sel_b), 16'd0);
    check("R1", "req", 16'(req), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8 plain register-file reads
    issue(1'b0, 1'b0, 3'd0, 3'd5, 3'd6, "R8");
    issue(1'b0, 1'b0, 3'd0, 3'd3, 3'd7, "R8");
    // R2 execute-stage forward
    issue(1'b1, 1'b0, 3'd3, 3'd1, 3'd2, "R2");
    issue(1'b0, 1'b0, 3'd0, 3'd3, 3'd5, "R2");
    bubble("R8"); bubble("R8");
    // R3 write-back forward
    issue(1'b1, 1'b0, 3'd4, 3'd1, 3'd1, "R3");
    bubble("R3");
    issue(1'b0, 1'b0, 3'd0, 3'd6, 3'd4, "R3");
    bubble("R8"); bubble("R8");
    // R4 hold-register forward
    issue(1'b1, 1'b0, 3'd6, 3'd2, 3'd3, "R4");
    bubble("R4"); bubble("R4");
    issue(1'b0, 1'b0, 3'd0, 3'd6, 3'd6, "R4");
    bubble("R8"); bubble("R8");
    // R5 youngest wins, R9 same source on both operands
    issue(1'b1, 1'b0, 3'd2, 3'd1, 3'd1, "R5");
    issue(1'b1, 1'b0, 3'd2, 3'd3, 3'd3, "R5");
    issue(1'b1, 1'b0, 3'd2, 3'd2, 3'd2, "R5");
    issue(1'b0, 1'b0, 3'd0, 3'd2, 3'd5, "R5");
    bubble("R8"); bubble("R8");
    // R6 destination 0 and disabled write
    issue(1'b1, 1'b0, 3'd0, 3'd1, 3'd2, "R6");
    issue(1'b0, 1'b0, 3'd5, 3'd0, 3'd0, "R6");
    issue(1'b0, 1'b0, 3'd0, 3'd5, 3'd0, "R6");
    bubble("R8"); bubble("R8");
    // R7 multiplier masks older ALU match
    issue(1'b1, 1'b0, 3'd1, 3'd4, 3'd5, "R7");
    issue(1'b1, 1'b1, 3'd1, 3'd6, 3'd7, "R7");
    issue(1'b0, 1'b0, 3'd0, 3'd1, 3'd3, "R7");
    bubble("R7"); bubble("R7");
    issue(1'b0, 1'b0, 3'd0, 3'd1, 3'd1, "R8");

    // dependent random stream, R5/R7/R9
    for (int n = 0; n < 3000; n++) begin
      logic we, mul;
      we  = ($urandom_range(0, 99) < 85);
      mul = we && ($urandom_range(0, 99) < 15);
      issue(we, mul, 3'($urandom_range(0, 4)), 3'($urandom_range(0, 4)),
            3'($urandom_range(0, 4)), "R5");
    end
    repeat (4) @(posedge clk);
    #6;
    finish_run();
  end
endmodule